// File: doc/BRIEF.md
# Four-Port Shared Memory with Per-Port Write Inhibit

This block is a 2048-word by 8-bit memory that four agents can use at once. Every port has its own address, write data, read data with a drive-enable flag, an active-low select, a read/write selector, an active-low output enable and an active-low write-inhibit input. There is no arbitration: any port may read or write any word in any cycle, including a word that another port is touching in the same cycle. An agent that must not write (for example because an external arbiter has granted the word to someone else) is held off by pulling its inhibit input low; its reads keep working.

All port controls are sampled on one rising clock edge. Writes are committed at that edge, and read data, the drive-enable flag, the standby flag and a per-port collision flag all appear one cycle after the sampled controls. Each port runs a small state register whose states are STANDBY (port deselected), IDLE (selected for reading with the output disabled), READ (selected, reading, output enabled), WRITE (an accepted write) and BLOCKED (a write attempt held off by the inhibit input). Every cycle the state moves to the one chosen by the sampled controls: deselect goes to STANDBY, a write request goes to WRITE or, when inhibited, to BLOCKED, and a read goes to READ or IDLE depending on the output enable. Reset places every port in STANDBY.

When several uninhibited ports write the same word in one cycle, the lowest-numbered port's data is stored and each of those ports raises its collision flag. A port reading a word that is being written in the same cycle receives the newly stored value.

Top module: `quad_share_ram`

## Requirements
- R1: All four ports can read four different words in the same cycle, each port receiving its own word on its read data one cycle later.
- R2: When a port's select (sel_n) is high, one cycle later that port reports standby=1, drv_en=0 and read data 0, and no write is made from it.
- R3: When sel_n is low, rd_wr is 0 (write) and wr_inh_n is high, the write data is stored at the port's address on that clock edge.
- R4: When wr_inh_n is low, a write request from that port leaves memory unchanged and raises no collision flag; a read on that port with wr_inh_n low works as normal.
- R5: When sel_n is low, rd_wr is 1 (read) and out_en_n is low, one cycle later drv_en is 1 and the read data holds the addressed word.
- R6: When out_en_n is high, one cycle later drv_en is 0 and the read data is 0, whatever the other controls are.
- R7: A port in write mode (sel_n low, rd_wr 0) has drv_en 0 one cycle later, even with out_en_n low, whether or not its write is inhibited.
- R8: A word written by one port is returned to every other port reading that address in a later cycle.
- R9: When two or more uninhibited ports write the same address in one cycle, the data of the lowest-numbered such port is stored.
- R10: One cycle after such a same-address write, the clash flag of every uninhibited port that took part is 1, and it is 0 for every other port.
- R11: A port reading an address that an uninhibited port writes in the same cycle receives the newly stored data (the winning data under R9).
- R12: After reset every port reports standby=1, drv_en=0, clash=0 and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; all controls sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | NPORTS | Active-low port select, one bit per port |
| rd_wr | input | NPORTS | 1 = read, 0 = write, per port |
| out_en_n | input | NPORTS | Active-low output enable, per port |
| wr_inh_n | input | NPORTS | Active-low write inhibit, per port |
| addr | input | NPORTS x AW | Word address of each port |
| wdata | input | NPORTS x DW | Write data of each port |
| rdata | output | NPORTS x DW | Read data of each port, 0 when not driven |
| drv_en | output | NPORTS | Output-drive enable of each port |
| standby | output | NPORTS | Port deselected in the previous cycle |
| clash | output | NPORTS | Port took part in a same-address write collision |

## Verification
The two functions that can fall in the same cycle are a write from one port and a read of the same word from another, and also several writes to one word. The bench provokes both by driving three ports to write one address while a fourth port either reads it or tries to write it with its inhibit low, and judges the outcome by the read value a cycle later (lowest uninhibited writer's data, also seen by a concurrent reader) and by the clash flags, which must mark exactly the uninhibited writers.

// File: rtl/qsr_pkg.sv
package qsr_pkg;

    typedef enum logic [2:0] {
        PS_STANDBY = 3'd0,
        PS_IDLE    = 3'd1,
        PS_READ    = 3'd2,
        PS_WRITE   = 3'd3,
        PS_BLOCKED = 3'd4
    } port_state_e;

endpackage

// File: rtl/qsr_port_ctl.sv
module qsr_port_ctl
    import qsr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          rd_wr,
    input  logic          out_en_n,
    input  logic          wr_inh_n,
    input  logic [DW-1:0] rd_word,
    output logic          wr_req,
    output logic [DW-1:0] rdata,
    output logic          drv_en,
    output logic          standby
);

    port_state_e state_q;
    port_state_e state_d;

    // Next state follows the sampled controls each cycle
    always_comb begin
        if (sel_n)
            state_d = PS_STANDBY;
        else if (!rd_wr)
            state_d = wr_inh_n ? PS_WRITE : PS_BLOCKED;
        else if (!out_en_n)
            state_d = PS_READ;
        else
            state_d = PS_IDLE;
    end

    // An accepted write request goes to the collision resolver this cycle
    assign wr_req = !sel_n && !rd_wr && wr_inh_n;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PS_STANDBY;
        else
            state_q <= state_d;
    end

    always_comb begin
        drv_en  = 1'b0;
        standby = 1'b0;
        rdata   = '0;
        unique case (state_q)
            PS_STANDBY: standby = 1'b1;
            PS_IDLE:    ;
            PS_READ: begin
                drv_en = 1'b1;
                rdata  = rd_word;
            end
            PS_WRITE:   ;
            PS_BLOCKED: ;
            default:    standby = 1'b1;
        endcase
    end

endmodule

// File: rtl/qsr_collide.sv
module qsr_collide #(
    parameter int NPORTS = 4,
    parameter int AW     = 11,
    parameter int DW     = 8
) (
    input  logic [NPORTS-1:0]         wr_req,
    input  logic [NPORTS-1:0][AW-1:0] addr,
    input  logic [NPORTS-1:0][DW-1:0] wdata,
    output logic [NPORTS-1:0]         wr_win,
    output logic [NPORTS-1:0]         clash_d,
    output logic [NPORTS-1:0]         fwd_hit,
    output logic [NPORTS-1:0][DW-1:0] fwd_data
);

    genvar gi;
    generate
        for (gi = 0; gi < NPORTS; gi++) begin : g_port
            logic lower_hit;
            logic other_hit;

            always_comb begin
                lower_hit = 1'b0;
                other_hit = 1'b0;
                for (int j = 0; j < NPORTS; j++) begin
                    if (j != gi && wr_req[j] && addr[j] == addr[gi]) begin
                        other_hit = 1'b1;
                        if (j < gi)
                            lower_hit = 1'b1;
                    end
                end
            end

            assign wr_win[gi]  = wr_req[gi] && !lower_hit;
            assign clash_d[gi] = wr_req[gi] && other_hit;

            // Scan from the top so the lowest-numbered writer is kept
            always_comb begin
                fwd_hit[gi]  = 1'b0;
                fwd_data[gi] = '0;
                for (int j = NPORTS - 1; j >= 0; j--) begin
                    if (wr_req[j] && addr[j] == addr[gi]) begin
                        fwd_hit[gi]  = 1'b1;
                        fwd_data[gi] = wdata[j];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/qsr_array.sv
module qsr_array #(
    parameter int NPORTS = 4,
    parameter int AW     = 11,
    parameter int DW     = 8
) (
    input  logic                      clk,
    input  logic [NPORTS-1:0]         wr_win,
    input  logic [NPORTS-1:0][AW-1:0] addr,
    input  logic [NPORTS-1:0][DW-1:0] wdata,
    input  logic [NPORTS-1:0]         fwd_hit,
    input  logic [NPORTS-1:0][DW-1:0] fwd_data,
    output logic [NPORTS-1:0][DW-1:0] rd_q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Winners always target distinct words, so order here is irrelevant
    always_ff @(posedge clk) begin
        for (int i = 0; i < NPORTS; i++) begin
            if (wr_win[i])
                mem[addr[i]] <= wdata[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPORTS; i++) begin
            rd_q[i] <= fwd_hit[i] ? fwd_data[i] : mem[addr[i]];
        end
    end

endmodule

// File: rtl/quad_share_ram.sv
module quad_share_ram #(
    parameter int NPORTS = 4,
    parameter int AW     = 11,
    parameter int DW     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORTS-1:0]         sel_n,
    input  logic [NPORTS-1:0]         rd_wr,
    input  logic [NPORTS-1:0]         out_en_n,
    input  logic [NPORTS-1:0]         wr_inh_n,
    input  logic [NPORTS-1:0][AW-1:0] addr,
    input  logic [NPORTS-1:0][DW-1:0] wdata,
    output logic [NPORTS-1:0][DW-1:0] rdata,
    output logic [NPORTS-1:0]         drv_en,
    output logic [NPORTS-1:0]         standby,
    output logic [NPORTS-1:0]         clash
);

    logic [NPORTS-1:0]         wr_req;
    logic [NPORTS-1:0]         wr_win;
    logic [NPORTS-1:0]         clash_d;
    logic [NPORTS-1:0]         fwd_hit;
    logic [NPORTS-1:0][DW-1:0] fwd_data;
    logic [NPORTS-1:0][DW-1:0] rd_q;

    genvar gp;
    generate
        for (gp = 0; gp < NPORTS; gp++) begin : g_ctl
            qsr_port_ctl #(.DW(DW)) u_ctl (
                .clk      (clk),
                .rst_n    (rst_n),
                .sel_n    (sel_n[gp]),
                .rd_wr    (rd_wr[gp]),
                .out_en_n (out_en_n[gp]),
                .wr_inh_n (wr_inh_n[gp]),
                .rd_word  (rd_q[gp]),
                .wr_req   (wr_req[gp]),
                .rdata    (rdata[gp]),
                .drv_en   (drv_en[gp]),
                .standby  (standby[gp])
            );
        end
    endgenerate

    qsr_collide #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_collide (
        .wr_req   (wr_req),
        .addr     (addr),
        .wdata    (wdata),
        .wr_win   (wr_win),
        .clash_d  (clash_d),
        .fwd_hit  (fwd_hit),
        .fwd_data (fwd_data)
    );

    qsr_array #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_array (
        .clk      (clk),
        .wr_win   (wr_win),
        .addr     (addr),
        .wdata    (wdata),
        .fwd_hit  (fwd_hit),
        .fwd_data (fwd_data),
        .rd_q     (rd_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            clash <= '0;
        else
            clash <= clash_d;
    end

endmodule

// File: rtl/quad_share_ram_chk.sv
module quad_share_ram_chk #(
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORTS-1:0] sel_n,
    input logic [NPORTS-1:0] rd_wr,
    input logic [NPORTS-1:0] out_en_n,
    input logic [NPORTS-1:0] wr_inh_n,
    input logic [NPORTS-1:0] drv_en,
    input logic [NPORTS-1:0] standby,
    input logic [NPORTS-1:0] clash
);

    // Set once a full cycle out of reset has passed
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else
            armed <= 1'b1;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NPORTS; gi++) begin : g_chk
            a_r2_deselect_standby: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                sel_n[gi] |=> (standby[gi] && !drv_en[gi]));

            a_r5_read_drives: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                (!sel_n[gi] && rd_wr[gi] && !out_en_n[gi]) |=> drv_en[gi]);

            a_r6_oe_high_quiet: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                out_en_n[gi] |=> !drv_en[gi]);

            a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                (!sel_n[gi] && !rd_wr[gi]) |=> !drv_en[gi]);

            a_r4_inhibit_no_clash: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                !wr_inh_n[gi] |=> !clash[gi]);

            a_r10_clash_needs_write: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                clash[gi] |-> $past(!sel_n[gi] && !rd_wr[gi] && wr_inh_n[gi]));
        end
    endgenerate

    a_r12_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (drv_en == '0 && clash == '0 && standby == '1));

endmodule

bind quad_share_ram quad_share_ram_chk #(.NPORTS(NPORTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .rd_wr    (rd_wr),
    .out_en_n (out_en_n),
    .wr_inh_n (wr_inh_n),
    .drv_en   (drv_en),
    .standby  (standby),
    .clash    (clash)
);

// File: tb/quad_share_ram_bench.sv
module quad_share_ram_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int AW = 11;
    localparam int DW = 8;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [NP-1:0]         sel_n;
    logic [NP-1:0]         rd_wr;
    logic [NP-1:0]         out_en_n;
    logic [NP-1:0]         wr_inh_n;
    logic [NP-1:0][AW-1:0] addr;
    logic [NP-1:0][DW-1:0] wdata;
    logic [NP-1:0][DW-1:0] rdata;
    logic [NP-1:0]         drv_en;
    logic [NP-1:0]         standby;
    logic [NP-1:0]         clash;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    quad_share_ram #(.NPORTS(NP), .AW(AW), .DW(DW)) u_quad_share_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .rd_wr    (rd_wr),
        .out_en_n (out_en_n),
        .wr_inh_n (wr_inh_n),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .drv_en   (drv_en),
        .standby  (standby),
        .clash    (clash)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge; outputs are sampled a quarter period later
    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD / 4);
    endtask

    task automatic idle_all();
        sel_n    = '1;
        rd_wr    = '1;
        out_en_n = '1;
        wr_inh_n = '1;
        addr     = '0;
        wdata    = '0;
    endtask

    task automatic do_write(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic inh_n);
        sel_n[p]    = 1'b0;
        rd_wr[p]    = 1'b0;
        out_en_n[p] = 1'b0;
        wr_inh_n[p] = inh_n;
        addr[p]     = a;
        wdata[p]    = d;
    endtask

    task automatic do_read(input int p, input logic [AW-1:0] a, input logic oe_n);
        sel_n[p]    = 1'b0;
        rd_wr[p]    = 1'b1;
        out_en_n[p] = oe_n;
        addr[p]     = a;
    endtask

    task automatic t_reset();
        idle_all();
        rst_n = 1'b0;
        repeat (3) step();
        // R12: reset state
        chk("R12 standby", 32'(standby), 32'hF);
        chk("R12 drv_en", 32'(drv_en), 32'h0);
        chk("R12 clash", 32'(clash), 32'h0);
        chk("R12 rdata", 32'(rdata), 32'h0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_write_read();
        idle_all();
        do_write(0, 11'h010, 8'h5A, 1'b1);
        step();
        idle_all();
        for (int p = 1; p < NP; p++) do_read(p, 11'h010, 1'b0);
        step();
        // R3, R5, R8: port 0 write seen by ports 1..3
        chk("R5 drv_en", 32'(drv_en), 32'hE);
        for (int p = 1; p < NP; p++) chk("R8 cross-port read", 32'(rdata[p]), 32'h5A);
        chk("R3 stored word", 32'(rdata[1]), 32'h5A);
    endtask

    task automatic t_parallel();
        idle_all();
        for (int p = 0; p < NP; p++) do_write(p, 11'(12'h400 + p), 8'(8'hC0 + p), 1'b1);
        step();
        chk("R10 distinct writes no clash", 32'(clash), 32'h0);
        idle_all();
        for (int p = 0; p < NP; p++) do_read(p, 11'(12'h400 + ((p + 1) % NP)), 1'b0);
        step();
        // R1: four different words read in one cycle
        for (int p = 0; p < NP; p++) chk("R1 parallel read", 32'(rdata[p]), 32'(8'hC0 + ((p + 1) % NP)));
    endtask

    task automatic t_inhibit();
        idle_all();
        do_write(2, 11'h010, 8'hFF, 1'b0);
        step();
        chk("R4 inhibited write no clash", 32'(clash), 32'h0);
        chk("R7 blocked write not driven", 32'(drv_en[2]), 32'h0);
        idle_all();
        do_read(2, 11'h010, 1'b0);
        wr_inh_n[2] = 1'b0;
        step();
        chk("R4 read under inhibit drives", 32'(drv_en[2]), 32'h1);
        chk("R4 memory unchanged", 32'(rdata[2]), 32'h5A);
    endtask

    task automatic t_oe_and_write_mode();
        idle_all();
        do_read(1, 11'h010, 1'b1);
        do_write(3, 11'h020, 8'h3C, 1'b1);
        step();
        chk("R6 oe high no drive", 32'(drv_en[1]), 32'h0);
        chk("R6 oe high rdata zero", 32'(rdata[1]), 32'h0);
        chk("R6 selected not standby", 32'(standby[1]), 32'h0);
        chk("R7 write mode no drive", 32'(drv_en[3]), 32'h0);
    endtask

    task automatic t_standby();
        idle_all();
        rd_wr[0] = 1'b0;
        out_en_n[0] = 1'b0;
        addr[0] = 11'h010;
        wdata[0] = 8'h99;
        step();
        chk("R2 deselected standby", 32'(standby[0]), 32'h1);
        chk("R2 deselected no drive", 32'(drv_en[0]), 32'h0);
        idle_all();
        do_read(1, 11'h010, 1'b0);
        step();
        chk("R2 deselected write ignored", 32'(rdata[1]), 32'h5A);
    endtask

    task automatic t_collide();
        idle_all();
        do_write(0, 11'h100, 8'h44, 1'b0);
        do_write(1, 11'h100, 8'h11, 1'b1);
        do_write(2, 11'h100, 8'h22, 1'b1);
        do_write(3, 11'h100, 8'h33, 1'b1);
        step();
        // R10: only uninhibited writers flagged
        chk("R10 clash flags", 32'(clash), 32'hE);
        idle_all();
        do_read(3, 11'h100, 1'b0);
        step();
        chk("R9 lowest writer wins", 32'(rdata[3]), 32'h11);
        chk("R10 clash clears", 32'(clash), 32'h0);
    endtask

    task automatic t_forward();
        idle_all();
        do_write(0, 11'h200, 8'h7E, 1'b1);
        do_read(1, 11'h200, 1'b0);
        step();
        chk("R11 write-through", 32'(rdata[1]), 32'h7E);
        idle_all();
        do_write(2, 11'h300, 8'hA1, 1'b1);
        do_write(3, 11'h300, 8'hB2, 1'b1);
        do_read(0, 11'h300, 1'b0);
        step();
        chk("R11 write-through with R9 winner", 32'(rdata[0]), 32'hA1);
        chk("R10 pair clash", 32'(clash), 32'hC);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_all();
        #(CLK_PERIOD / 4);
        t_reset();
        t_write_read();
        t_parallel();
        t_inhibit();
        t_oe_and_write_mode();
        t_standby();
        t_collide();
        t_forward();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule